// File: doc/BRIEF.md
# Dual-Gain PID Duty Regulator

This block closes the voltage loop of a bidirectional buck-boost power stage. Each time a sample strobe arrives it takes a signed voltage setpoint and a signed measured output voltage and forms the control error. It then runs proportional, integral and derivative paths and sums them. The result is clamped to a duty command between zero and one, and that command drives a downstream PWM modulator.

Step-down and step-up operation each need different loop dynamics, so the block stores two gain sets and a mode input selects one for each sample. Switching mode invalidates the loop history. On the first sample in the new mode the accumulated integral and the stored previous error are therefore discarded. All data are signed 32-bit words with 23 fractional bits (1.0 = 8388608). The integral and derivative gains are pre-scaled by the 2 µs sample period before they are stored.

Top module: `dual_gain_pid`

## Requirements
- R1: The error is ref_i minus meas_i, saturated to the signed 32-bit range (most positive 2147483647, most negative -2147483648).
- R2: A sample presented with sample_valid_i high at a rising edge produces a one-cycle out_valid_o pulse three rising edges later, counting the capturing edge as the first. A new sample may be accepted on every cycle.
- R3: The proportional term is floor(KP × e / 2^23), where e is the error of R1.
- R4: The integral increment is floor(KI × e / 2^23). The command is u = P + I + increment + D, where I is the integrator value from before this sample.
- R5: The derivative term is floor(KD × (e − e_prev) / 2^23). e_prev is the error of the previous sample and is 0 after reset.
- R6: mode_i = 0 selects the step-down gains (KP 3330, KI 292, KD 9479). mode_i = 1 selects the step-up gains (KP 948, KI 72, KD 3137). The mode is sampled together with each sample.
- R7: duty_o equals u clamped to the range 0 to 8388608.
- R8: When u lies inside the range 0 to 8388608, the integrator becomes I + increment, clamped to that same range. When u lies outside it, the integrator keeps its value.
- R9: When the sampled mode differs from the mode of the previous accepted sample, I and e_prev are taken as 0 for that sample. Reset leaves the mode at 0.
- R10: While rst is high, duty_o and out_valid_o are 0 and the integrator, previous error and mode history are cleared.
- R11: duty_o holds its value between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid_i | input | 1 | Starts one controller update |
| mode_i | input | 1 | 0 step-down gains, 1 step-up gains |
| ref_i | input | 32 | Voltage setpoint, signed Q23 |
| meas_i | input | 32 | Measured output voltage, signed Q23 |
| duty_o | output | 32 | Clamped duty command, Q23 |
| out_valid_o | output | 1 | One-cycle pulse when duty_o updates |

## Verification
The assertions check on every cycle that the duty stays in range and that the integrator stays within its bounds. They also check that the integrator freezes while the command is clamped and is zeroed when a clamped sample follows a mode change. Further cycle checks cover the error sign under saturation, the three-cycle strobe latency and that the duty holds between pulses. The exact arithmetic values can only be shown by the bench's scenarios: rounding of each term, gain selection, integral build-up into saturation and recovery from it, and the effect of a mode change on the derivative. The same applies to back-to-back sample streams and reset in the middle of a run.

// File: rtl/dgpid_pkg.sv
package dgpid_pkg;
  typedef enum logic {
    MODE_STEP_DOWN = 1'b0,
    MODE_STEP_UP   = 1'b1
  } pid_mode_e;

  localparam int unsigned NUM_MODES = 2;
endpackage

// File: rtl/dgpid_err_stage.sv
module dgpid_err_stage
  import dgpid_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  pid_mode_e           mode_i,
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] meas_i,
  output logic                valid_o,
  output pid_mode_e           mode_o,
  output logic                clr_o,
  output logic signed [W-1:0] err_o
);
  localparam logic signed [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0]   diff;
  logic signed [W-1:0] err_sat;
  pid_mode_e           last_mode;

  assign diff = {ref_i[W-1], ref_i} - {meas_i[W-1], meas_i};

  always_comb begin
    if (diff[W] != diff[W-1]) err_sat = diff[W] ? NEG_LIM : POS_LIM;
    else                      err_sat = W'(diff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      mode_o    <= MODE_STEP_DOWN;
      clr_o     <= 1'b0;
      err_o     <= '0;
      last_mode <= MODE_STEP_DOWN;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        err_o     <= err_sat;
        mode_o    <= mode_i;
        clr_o     <= (mode_i != last_mode);
        last_mode <= mode_i;
      end
    end
  end

  AST_ERR_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
    valid_i && !ref_i[W-1] && meas_i[W-1] |=> !err_o[W-1]); // R1

endmodule

// File: rtl/dgpid_gain_bank.sv
module dgpid_gain_bank #(
  parameter int W      = 32,
  parameter int NM     = 2,
  parameter int SEL_W  = 1,
  parameter logic [NM*W-1:0] KP_TAB = '0,
  parameter logic [NM*W-1:0] KI_TAB = '0,
  parameter logic [NM*W-1:0] KD_TAB = '0
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]     kp_o,
  output logic [W-1:0]     ki_o,
  output logic [W-1:0]     kd_o
);
  logic [W-1:0] kp_arr [NM];
  logic [W-1:0] ki_arr [NM];
  logic [W-1:0] kd_arr [NM];

  for (genvar g = 0; g < NM; g++) begin : g_set
    assign kp_arr[g] = KP_TAB[g*W +: W];
    assign ki_arr[g] = KI_TAB[g*W +: W];
    assign kd_arr[g] = KD_TAB[g*W +: W];
  end

  assign kp_o = kp_arr[sel_i];
  assign ki_o = ki_arr[sel_i];
  assign kd_o = kd_arr[sel_i];
endmodule

// File: rtl/dgpid_term_stage.sv
module dgpid_term_stage #(
  parameter int W     = 32,
  parameter int FRAC  = 23,
  parameter int ACC_W = 66
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic                    clr_i,
  input  logic signed [W-1:0]     err_i,
  input  logic [W-1:0]            kp_i,
  input  logic [W-1:0]            ki_i,
  input  logic [W-1:0]            kd_i,
  output logic                    valid_o,
  output logic                    clr_o,
  output logic signed [ACC_W-1:0] p_o,
  output logic signed [ACC_W-1:0] kie_o,
  output logic signed [ACC_W-1:0] d_o
);
  logic signed [W-1:0]     err_prev;
  logic signed [W-1:0]     prev_eff;
  logic signed [ACC_W-1:0] err_x, dlt_x, kp_x, ki_x, kd_x;
  logic signed [ACC_W-1:0] p_full, i_full, d_full;

  assign prev_eff = clr_i ? '0 : err_prev;
  assign err_x    = ACC_W'(err_i);
  assign dlt_x    = ACC_W'(err_i) - ACC_W'(prev_eff);
  assign kp_x     = ACC_W'($signed(kp_i));
  assign ki_x     = ACC_W'($signed(ki_i));
  assign kd_x     = ACC_W'($signed(kd_i));
  assign p_full   = kp_x * err_x;
  assign i_full   = ki_x * err_x;
  assign d_full   = kd_x * dlt_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      clr_o    <= 1'b0;
      p_o      <= '0;
      kie_o    <= '0;
      d_o      <= '0;
      err_prev <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        clr_o    <= clr_i;
        p_o      <= p_full >>> FRAC;
        kie_o    <= i_full >>> FRAC;
        d_o      <= d_full >>> FRAC;
        err_prev <= err_i;
      end
    end
  end

  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> err_prev == $past(err_i)); // R5

endmodule

// File: rtl/dgpid_sum_stage.sv
module dgpid_sum_stage #(
  parameter int W     = 32,
  parameter int FRAC  = 23,
  parameter int ACC_W = 66
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_i,
  input  logic                    clr_i,
  input  logic signed [ACC_W-1:0] p_i,
  input  logic signed [ACC_W-1:0] kie_i,
  input  logic signed [ACC_W-1:0] d_i,
  output logic [W-1:0]            duty_o,
  output logic                    out_valid_o
);
  localparam logic signed [ACC_W-1:0] ONE_A =
    {{(ACC_W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};
  localparam logic signed [W-1:0] ONE_W =
    {{(W-FRAC-1){1'b0}}, 1'b1, {FRAC{1'b0}}};

  logic signed [W-1:0]     integ_q;
  logic signed [ACC_W-1:0] integ_eff, u_sum, i_next, i_clamped;
  logic                    u_low, u_high;

  assign integ_eff = clr_i ? '0 : ACC_W'(integ_q);
  assign u_sum     = p_i + d_i + kie_i + integ_eff;
  assign u_low     = (u_sum < 0);
  assign u_high    = (u_sum > ONE_A);
  assign i_next    = integ_eff + kie_i;

  always_comb begin
    if (i_next < 0)          i_clamped = '0;
    else if (i_next > ONE_A) i_clamped = ONE_A;
    else                     i_clamped = i_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_o      <= '0;
      out_valid_o <= 1'b0;
      integ_q     <= '0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        if (u_low)       duty_o <= '0;
        else if (u_high) duty_o <= ONE_W;
        else             duty_o <= W'(u_sum);
        if (u_low || u_high) integ_q <= W'(integ_eff);
        else                 integ_q <= W'(i_clamped);
      end
    end
  end

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> ($signed(duty_o) >= 0 && $signed(duty_o) <= ONE_W)); // R7
  AST_INTEG_BOUND: assert property (@(posedge clk) disable iff (rst)
    integ_q >= 0 && integ_q <= ONE_W); // R8
  AST_WINDUP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    valid_i && !clr_i && (u_low || u_high) |=> $stable(integ_q)); // R8
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    valid_i && clr_i && (u_low || u_high) |=> integ_q == '0); // R9

endmodule

// File: rtl/dual_gain_pid.sv
module dual_gain_pid
  import dgpid_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FRAC_W     = 23,
  parameter int DOWN_KP    = 3330,
  parameter int DOWN_KI    = 292,
  parameter int DOWN_KD    = 9479,
  parameter int UP_KP      = 948,
  parameter int UP_KI      = 72,
  parameter int UP_KD      = 3137
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [DATA_W-1:0] meas_i,
  output logic [DATA_W-1:0] duty_o,
  output logic              out_valid_o
);
  localparam int ACC_W = 2*DATA_W + 2;
  localparam int NM    = int'(NUM_MODES);
  localparam int SEL_W = $clog2(NM);
  localparam logic [NM*DATA_W-1:0] KP_TAB = {DATA_W'(UP_KP), DATA_W'(DOWN_KP)};
  localparam logic [NM*DATA_W-1:0] KI_TAB = {DATA_W'(UP_KI), DATA_W'(DOWN_KI)};
  localparam logic [NM*DATA_W-1:0] KD_TAB = {DATA_W'(UP_KD), DATA_W'(DOWN_KD)};

  logic                     a_valid, a_clr, b_valid, b_clr;
  pid_mode_e                a_mode, mode_in;
  logic signed [DATA_W-1:0] a_err;
  logic [DATA_W-1:0]        kp, ki, kd;
  logic signed [ACC_W-1:0]  b_p, b_kie, b_d;
  logic [SEL_W-1:0]         gain_sel;

  assign mode_in  = pid_mode_e'(mode_i);
  assign gain_sel = SEL_W'(a_mode);

  dgpid_err_stage #(.W(DATA_W)) u_err (
    .clk(clk), .rst(rst), .valid_i(sample_valid_i), .mode_i(mode_in),
    .ref_i($signed(ref_i)), .meas_i($signed(meas_i)),
    .valid_o(a_valid), .mode_o(a_mode), .clr_o(a_clr), .err_o(a_err));

  dgpid_gain_bank #(.W(DATA_W), .NM(NM), .SEL_W(SEL_W),
    .KP_TAB(KP_TAB), .KI_TAB(KI_TAB), .KD_TAB(KD_TAB)) u_gains (
    .sel_i(gain_sel), .kp_o(kp), .ki_o(ki), .kd_o(kd));

  dgpid_term_stage #(.W(DATA_W), .FRAC(FRAC_W), .ACC_W(ACC_W)) u_terms (
    .clk(clk), .rst(rst), .valid_i(a_valid), .clr_i(a_clr), .err_i(a_err),
    .kp_i(kp), .ki_i(ki), .kd_i(kd),
    .valid_o(b_valid), .clr_o(b_clr), .p_o(b_p), .kie_o(b_kie), .d_o(b_d));

  dgpid_sum_stage #(.W(DATA_W), .FRAC(FRAC_W), .ACC_W(ACC_W)) u_sum (
    .clk(clk), .rst(rst), .valid_i(b_valid), .clr_i(b_clr),
    .p_i(b_p), .kie_i(b_kie), .d_i(b_d),
    .duty_o(duty_o), .out_valid_o(out_valid_o));

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> $past(sample_valid_i, 3)); // R2
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid_o |-> $stable(duty_o)); // R11

endmodule

// File: tb/dual_gain_pid_bench.sv
module dual_gain_pid_bench;
  localparam longint ONE  = 64'sd8388608;
  localparam longint EMAX = 64'sd2147483647;
  localparam longint EMIN = -64'sd2147483648;

  typedef struct packed {
    logic        mode;
    logic [31:0] r;
    logic [31:0] m;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'sd83886080,    32'sd0},
    '{1'b0, 32'sd83886080,    32'sd41943040},
    '{1'b0, 32'sd83886080,    32'sd100663296},
    '{1'b0, -32'sd25165824,   32'sd33554432},
    '{1'b0, 32'sd2139095040,  -32'sd2139095040},
    '{1'b1, 32'sd167772160,   32'sd125829120},
    '{1'b1, 32'sd167772160,   32'sd163577856},
    '{1'b1, 32'sd0,           32'sd0},
    '{1'b0, 32'sd8388608,     32'sd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] ref_i = '0;
  logic [31:0] meas_i = '0;
  logic [31:0] duty_o;
  logic        out_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint m_integ, m_prev;
  logic   m_mode;

  always #10 clk = ~clk;

  dual_gain_pid u_dual_gain_pid (
    .clk(clk), .rst(rst), .sample_valid_i(sample_valid_i), .mode_i(mode_i),
    .ref_i(ref_i), .meas_i(meas_i), .duty_o(duty_o), .out_valid_o(out_valid_o));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_integ = 0; m_prev = 0; m_mode = 1'b0;
  endfunction

  function automatic longint model_step(input logic md, input logic [31:0] r,
                                        input logic [31:0] m);
    longint e, kp, ki, kd, p, kie, d, u, inx, duty;
    e = longint'($signed(r)) - longint'($signed(m));            // R1
    if (e > EMAX) e = EMAX;
    if (e < EMIN) e = EMIN;
    if (md != m_mode) begin m_integ = 0; m_prev = 0; end        // R9
    m_mode = md;
    kp = md ? 948 : 3330;                                       // R6
    ki = md ? 72 : 292;
    kd = md ? 3137 : 9479;
    p   = (kp * e) >>> 23;                                      // R3
    kie = (ki * e) >>> 23;                                      // R4
    d   = (kd * (e - m_prev)) >>> 23;                           // R5
    u = p + m_integ + kie + d;
    if (u < 0) duty = 0;                                        // R7
    else if (u > ONE) duty = ONE;
    else begin
      duty = u;
      inx = m_integ + kie;                                      // R8
      m_integ = (inx < 0) ? 0 : ((inx > ONE) ? ONE : inx);
    end
    m_prev = e;
    return duty;
  endfunction

  task automatic run_sample(input logic md, input logic [31:0] r,
                            input logic [31:0] m, input string req);
    longint exp;
    exp = model_step(md, r, m);
    @(negedge clk);
    mode_i = md; ref_i = r; meas_i = m; sample_valid_i = 1'b1;
    @(negedge clk);
    sample_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({req, " R2 valid"}, longint'(out_valid_o), 1);
    chk(req, longint'(duty_o), exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 duty in reset", longint'(duty_o), 0);
    chk("R10 valid in reset", longint'(out_valid_o), 0);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint e1, e2, e3;
    model_reset();
    do_reset();

    // Table walk: gain sets, rounding, saturation of error, mode changes
    for (int i = 0; i < NV; i++)
      run_sample(VECS[i].mode, VECS[i].r, VECS[i].m, "R1 R3 R4 R5 R6 R9 table");

    // R11: duty holds with no strobe
    e1 = longint'(duty_o);
    repeat (5) @(negedge clk);
    chk("R11 duty hold", longint'(duty_o), e1);
    chk("R2 no spurious valid", longint'(out_valid_o), 0);

    // R7 low clamp from a fresh state
    do_reset();
    run_sample(1'b0, 32'sd0, 32'sd83886080, "R7 low clamp");
    chk("R7 low clamp value", longint'(duty_o), 0);

    // R8 integral build-up into upper clamp, then recovery
    for (int i = 0; i < 150; i++)
      run_sample(1'b0, 32'sd2139095040, 32'sd0, "R4 R8 windup");
    chk("R7 high clamp value", longint'(duty_o), ONE);
    run_sample(1'b0, 32'sd0, 32'sd8388608, "R8 recovery after clamp");
    run_sample(1'b0, 32'sd4194304, 32'sd0, "R8 recovery step");

    // R9 mode change clears history
    run_sample(1'b1, 32'sd83886080, 32'sd0, "R9 switch to step-up");
    run_sample(1'b1, 32'sd83886080, 32'sd0, "R9 step-up hold");

    // R2 back-to-back samples on consecutive cycles
    e1 = model_step(1'b1, 32'sd41943040, 32'sd0);
    e2 = model_step(1'b1, 32'sd16777216, 32'sd0);
    e3 = model_step(1'b1, 32'sd0, 32'sd8388608);
    @(negedge clk);
    sample_valid_i = 1'b1; mode_i = 1'b1; ref_i = 32'sd41943040; meas_i = 32'sd0;
    @(negedge clk);
    ref_i = 32'sd16777216;
    @(negedge clk);
    ref_i = 32'sd0; meas_i = 32'sd8388608;
    @(negedge clk);
    sample_valid_i = 1'b0;
    chk("R2 stream first", longint'(duty_o), e1);
    chk("R2 stream first valid", longint'(out_valid_o), 1);
    @(negedge clk);
    chk("R2 stream second", longint'(duty_o), e2);
    @(negedge clk);
    chk("R2 stream third", longint'(duty_o), e3);
    @(negedge clk);
    chk("R2 pulse ends", longint'(out_valid_o), 0);

    // R10 reset mid-run then resume
    do_reset();
    run_sample(1'b0, 32'sd83886080, 32'sd0, "R10 R5 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule